// File: doc/BRIEF.md
# Host Bus Byte-Lane Adapter

This block sits between an internal DMA engine and a 16-bit host memory that is organised in words but addressed in bytes. It accepts one request at a time (address, byte-or-word size, write data, direction) and turns it into a bus cycle. The cycle has a one-cycle address strobe, an address, lane-select outputs and write data. It then waits for the memory's ready input and returns the read data to the requester with a one-cycle response pulse.

Three configuration inputs shape the signalling. The first sets the active level of the address strobe: active high for a latch-enable style, active low for a strobe style. The second chooses how the addressed byte lane is shown. In one scheme a single byte flag is decoded together with address bit 0. In the other, two active-low lane masks mark the lanes directly. The third exchanges the two bytes of the data word, for both writes and reads. The configuration is taken only while no bus cycle is running, so a change never disturbs a cycle in flight.

Top module: `hbus_lane_adapter`

## Requirements
- R1: After reset the adapter is idle. It shows `req_accept`=1, `bus_active`=0, `bus_as`=1 (the inactive level of the reset polarity), `bus_bmask_n`=2'b11, `bus_byte`=0, `bus_wr`=0, zero address and write data, and `resp_valid`=0.
- R2: While idle the adapter accepts a request on the clock edge where `req_valid`=1. It captures the request fields and the three configuration inputs at that edge, and `req_accept` stays 0 until the cycle completes.
- R3: `bus_as` is at its active level for exactly the first cycle after acceptance, and at the inactive level otherwise. The active level is 1 when `cfg_strobe_hi`=1 and 0 when it is 0.
- R4: With `cfg_mask_mode`=0, `bus_byte`=1 marks a byte access and `bus_byte`=0 a word access. `bus_addr` bit 0 tells which byte is meant, and `bus_bmask_n` stays 2'b11.
- R5: With `cfg_mask_mode`=1, `bus_byte` stays 0 and `bus_bmask_n` is active low. Bit 0 marks the low lane (data bits 7:0, address bit 0 = 0) and bit 1 the high lane (bits 15:8, address bit 0 = 1). A word access drives 2'b00.
- R6: After the strobe cycle the adapter waits while `bus_ready`=0 and completes on the first edge where `bus_ready`=1. A ready level during the strobe cycle is ignored.
- R7: `bus_wdata` equals the request's write data during a write cycle, with bytes [15:8] and [7:0] exchanged when the captured swap bit is 1.
- R8: `resp_valid` pulses for one cycle after the completing edge. `resp_rdata` carries `bus_rdata` sampled at that edge, byte-exchanged when the captured swap bit is 1, and holds its value afterwards.
- R9: Changes of the configuration inputs during a bus cycle do not affect that cycle's strobe level, lane outputs or data ordering.
- R10: Outside a bus cycle `bus_wr`=0, `bus_byte`=0, `bus_bmask_n`=2'b11, and `bus_addr`/`bus_wdata` are zero. During a read cycle `bus_wdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_strobe_hi | input | 1 | 1: strobe active high, 0: active low |
| cfg_mask_mode | input | 1 | 0: byte flag with address bit 0, 1: lane masks |
| cfg_swap | input | 1 | Exchange the two data bytes |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_byte | input | 1 | 1: byte access, 0: word access |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Adapter idle, request taken this edge |
| resp_valid | output | 1 | Cycle completed pulse |
| resp_rdata | output | 16 | Returned read data |
| bus_as | output | 1 | Address strobe |
| bus_active | output | 1 | Bus cycle in progress |
| bus_addr | output | AW | Bus address |
| bus_byte | output | 1 | Byte flag (flag scheme) |
| bus_bmask_n | output | 2 | Active-low lane masks (mask scheme) |
| bus_wr | output | 1 | Write direction |
| bus_wdata | output | 16 | Write data to memory |
| bus_rdata | input | 16 | Read data from memory |
| bus_ready | input | 1 | Memory ready |

## Verification
The assertions check on every cycle that the strobe is active for a single cycle, that the captured configuration stays still while a cycle runs, and that the lane outputs stay quiet when idle. They also check that the mask scheme always marks a lane and that the byte flag never appears in the mask scheme. They check that a waiting cycle without ready stays waiting and that the response is a single pulse. Only the bench's scenarios can show the right values: the lane chosen from address bit 0, the byte order of write and read data under each swap setting, the ready input being ignored during the strobe, and that configuration flips in mid-cycle take effect only on the next cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT} seq_st_t;

  typedef struct packed {
    logic strobe_hi;
    logic mask_mode;
    logic swap;
  } hcfg_t;

  // active-low lane masks: word -> all lanes, byte -> lane chosen by a0
  function automatic logic [NB-1:0] lane_mask_n(input logic is_byte, input logic a0);
    logic [NB-1:0] m;
    m = '0;
    if (is_byte) m = a0 ? 2'b01 : 2'b10;
    return m;
  endfunction

  // strobe level for a given phase and polarity
  function automatic logic strobe_level(input logic in_addr_phase, input logic hi);
    return in_addr_phase ? hi : ~hi;
  endfunction
endpackage

// File: rtl/hbus_swap.sv
module hbus_swap
  import hbus_pkg::*;
(
  input  logic [DW-1:0] din,
  input  logic          en,
  output logic [DW-1:0] dout
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign dout[g*8 +: 8] = en ? din[(NB-1-g)*8 +: 8] : din[g*8 +: 8];
  end
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hcfg_t         cfg,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] rdata_in,
  output hcfg_t         cfg_q,
  output logic          busy,
  output logic          addr_phase,
  output logic          lat_write,
  output logic          lat_byte,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          req_accept,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata
);
  seq_st_t st;
  logic    start_ev;
  logic    done_ev;

  assign start_ev   = (st == ST_IDLE) && req_valid;
  assign done_ev    = (st == ST_WAIT) && bus_ready;
  assign busy       = (st != ST_IDLE);
  assign addr_phase = (st == ST_ADDR);
  assign req_accept = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cfg_q      <= '0;
      lat_write  <= 1'b0;
      lat_byte   <= 1'b0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          cfg_q <= cfg;
          if (start_ev) begin
            lat_write <= req_write;
            lat_byte  <= req_byte;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            st        <= ST_ADDR;
          end
        end
        ST_ADDR: st <= ST_WAIT;
        ST_WAIT: begin
          if (done_ev) begin
            resp_valid <= 1'b1;
            resp_rdata <= rdata_in;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR) && !req_accept);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !bus_ready) |=> (st == ST_WAIT) && !resp_valid);

  // R8
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

// File: rtl/hbus_lane_enc.sv
module hbus_lane_enc
  import hbus_pkg::*;
(
  input  logic          active,
  input  logic          mask_mode,
  input  logic          is_byte,
  input  logic          a0,
  input  logic          write,
  output logic          byte_flag,
  output logic [NB-1:0] bmask_n,
  output logic          wr
);
  always_comb begin
    byte_flag = 1'b0;
    bmask_n   = '1;
    wr        = active && write;
    if (active) begin
      if (mask_mode) bmask_n   = lane_mask_n(is_byte, a0);
      else           byte_flag = is_byte;
    end
  end
endmodule

// File: rtl/hbus_lane_adapter.sv
module hbus_lane_adapter
  import hbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_strobe_hi,
  input  logic          cfg_mask_mode,
  input  logic          cfg_swap,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_accept,
  output logic          resp_valid,
  output logic [15:0]   resp_rdata,
  output logic          bus_as,
  output logic          bus_active,
  output logic [AW-1:0] bus_addr,
  output logic          bus_byte,
  output logic [1:0]    bus_bmask_n,
  output logic          bus_wr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ready
);
  hcfg_t         cfg_in;
  hcfg_t         cfg_q;
  logic          busy;
  logic          addr_phase;
  logic          lat_write;
  logic          lat_byte;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic [DW-1:0] wdata_sw;
  logic [DW-1:0] rdata_sw;

  assign cfg_in = '{strobe_hi: cfg_strobe_hi, mask_mode: cfg_mask_mode, swap: cfg_swap};

  hbus_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_in),
    .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_ready(bus_ready), .rdata_in(rdata_sw),
    .cfg_q(cfg_q), .busy(busy), .addr_phase(addr_phase),
    .lat_write(lat_write), .lat_byte(lat_byte), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .req_accept(req_accept),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  hbus_swap u_wswap (.din(lat_wdata), .en(cfg_q.swap), .dout(wdata_sw));
  hbus_swap u_rswap (.din(bus_rdata), .en(cfg_q.swap), .dout(rdata_sw));

  hbus_lane_enc u_lane (
    .active(busy), .mask_mode(cfg_q.mask_mode), .is_byte(lat_byte),
    .a0(lat_addr[0]), .write(lat_write),
    .byte_flag(bus_byte), .bmask_n(bus_bmask_n), .wr(bus_wr)
  );

  assign bus_as     = strobe_level(addr_phase, cfg_q.strobe_hi);
  assign bus_active = busy;
  assign bus_addr   = busy ? lat_addr : '0;
  assign bus_wdata  = bus_wr ? wdata_sw : '0;

  // R3
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as == cfg_q.strobe_hi) |=> (bus_as != cfg_q.strobe_hi));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> (bus_bmask_n == 2'b11) && !bus_wr && !bus_byte);

  // R5
  mask_marks_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && cfg_q.mask_mode) |-> (bus_bmask_n != 2'b11) && !bus_byte);

  // R4
  flag_scheme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_byte |-> !cfg_q.mask_mode && (bus_bmask_n == 2'b11));
endmodule

// File: tb/hbus_lane_adapter_test.sv
`timescale 1ns/1ps
module hbus_lane_adapter_test;
  localparam int AW = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_strobe_hi = 0, cfg_mask_mode = 0, cfg_swap = 0;
  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_rdata = '0;
  logic bus_ready = 0;
  logic req_accept, resp_valid, bus_as, bus_active, bus_byte, bus_wr;
  logic [15:0] resp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_bmask_n;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hbus_lane_adapter #(.AW(AW)) uut (.*);

  // behavioural reference state
  int          m_st = 0;          // 0 idle, 1 strobe, 2 waiting
  bit          m_hi, m_mm, m_sw, m_wr, m_by, m_rv;
  int unsigned m_addr, m_wd, m_rd;

  function automatic int unsigned xchg(input int unsigned v);
    return ((v & 'hFF) << 8) | ((v >> 8) & 'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_hi = 0; m_mm = 0; m_sw = 0; m_wr = 0; m_by = 0;
      m_rv = 0; m_addr = 0; m_wd = 0; m_rd = 0;
    end else begin
      m_rv = 0;
      if (m_st == 0) begin
        m_hi = cfg_strobe_hi; m_mm = cfg_mask_mode; m_sw = cfg_swap;
        if (req_valid) begin
          m_wr = req_write; m_by = req_byte; m_addr = req_addr; m_wd = req_wdata;
          m_st = 1;
        end
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (bus_ready) begin
        m_rd = m_sw ? xchg(bus_rdata) : bus_rdata;
        m_rv = 1;
        m_st = 0;
      end
    end
  end

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit busy;
    int unsigned e_mask;
    busy = (m_st != 0);
    e_mask = 3;
    if (busy && m_mm) e_mask = !m_by ? 0 : ((m_addr & 1) ? 1 : 2);
    if (!rst_n) begin
      chk("R1 bus_as", bus_as, 1);
      chk("R1 bus_active", bus_active, 0);
      chk("R1 req_accept", req_accept, 1);
      chk("R1 bus_bmask_n", bus_bmask_n, 3);
      chk("R1 resp_valid", resp_valid, 0);
      chk("R1 bus_wr", bus_wr, 0);
    end else begin
      chk("R2 req_accept", req_accept, !busy);
      chk("R3/R9 bus_as", bus_as, (m_st == 1) ? m_hi : !m_hi);
      chk("R6 bus_active", bus_active, busy);
      chk("R4 bus_byte", bus_byte, busy && !m_mm && m_by);
      chk("R5 bus_bmask_n", bus_bmask_n, e_mask);
      chk("R4/R10 bus_addr", bus_addr, busy ? m_addr : 0);
      chk("R10 bus_wr", bus_wr, busy && m_wr);
      chk("R7 bus_wdata", bus_wdata, (busy && m_wr) ? (m_sw ? xchg(m_wd) : m_wd) : 0);
      chk("R8 resp_valid", resp_valid, m_rv);
      chk("R8 resp_rdata", resp_rdata, m_rd);
    end
  end

  always @(negedge clk) bus_rdata <= 16'($urandom);

  // one full bus cycle; early_rdy raises ready in the strobe cycle (R6),
  // flip inverts all configuration inputs mid-cycle (R9)
  task automatic run_cycle(input bit hi, mm, sw, wr, by, input int unsigned a,
                           input int unsigned d, input int dly, input bit early_rdy,
                           input bit flip);
    @(negedge clk);
    cfg_strobe_hi = hi; cfg_mask_mode = mm; cfg_swap = sw;
    req_write = wr; req_byte = by; req_addr = AW'(a); req_wdata = 16'(d);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_addr = '1; req_wdata = '1;
    if (flip) begin
      cfg_strobe_hi = !hi; cfg_mask_mode = !mm; cfg_swap = !sw;
    end
    bus_ready = early_rdy;
    @(negedge clk);
    bus_ready = 0;
    repeat (dly) @(negedge clk);
    bus_ready = 1;
    @(negedge clk);
    bus_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 R5 R7 R8: every configuration, size, lane and direction
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        run_cycle(c[2], c[1], c[0], k[0], k < 4, 'h1230 + 32'(k) * 'h101 + 32'(k >> 1),
                  'hA55A + 32'(c) * 'h1357, k % 3, 1'b0, 1'b0);
      end
    end
    // R6: ready during strobe ignored, long waits
    for (int k = 0; k < 6; k++)
      run_cycle(k[0], k[1], 1'b1, k[0], k[1], 'hFF01 + 32'(k), 'h0F0F, 4 + k, 1'b1, 1'b0);
    // R9: configuration flips inside the cycle
    for (int k = 0; k < 8; k++)
      run_cycle(k[2], k[1], k[0], k[0], k[1], 'h800000 + 32'(k), 'hBEEF, k % 2, 1'b0, 1'b1);
    // idle with request low: outputs quiet (R10)
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule